// File: doc/BRIEF.md
# Linked-List Triggered DMA Channel

This block is a single memory-to-memory DMA channel that follows a chain of descriptor nodes stored in memory. Each node names a source address, a destination address, a word count, a link to the next node, and an acknowledge address with a mask value. Software writes the address of the first node, picks one of sixteen hardware trigger inputs, and sets the enable bit. The channel then loads the first node and waits.

Each block starts on a rising edge of the selected trigger. A typical trigger is the transfer-complete pulse of another DMA channel that has just filled a buffer. The channel copies the block word by word. It then writes the node's mask to the node's acknowledge address, which clears the request at its source. Only after that write does it load the next node.

A null link ends the chain. At that point the channel clears its own enable bit and raises a chain-complete flag. If a link points back to an earlier node, the chain repeats until software clears the enable bit. Node fetches use a dedicated descriptor read port. Data reads, data writes and acknowledge writes share one memory port.

Top module: `llt_dma_chan`

## Requirements
- R1: After reset the channel is idle. It raises no memory or descriptor request, and the control, head and status registers read as zero.
- R2: Setting the enable bit (control register at offset 0, bit 0) makes the channel read six node words from the head address (offset 1), at consecutive word addresses. The word order is: source, destination, word count, link, acknowledge address, acknowledge mask. No data moves before a trigger.
- R3: Only a rising edge on the trigger input chosen by control bits [7:4] starts a block. Edges on the other fifteen inputs are ignored.
- R4: A block copies the node's word count of 32-bit words. Each word is read from the source and then written to the destination. Both addresses step by 4 bytes per word.
- R5: After the last data write of a block, the channel writes the acknowledge mask to the acknowledge address exactly once. A node with a word count of zero produces only that acknowledge write.
- R6: The next node is read from the link address only after the acknowledge write. A zero link ends the chain: the channel goes idle, the enable bit reads back 0, and the chain-complete flag is set.
- R7: A chain whose links loop back runs one block per trigger without ever ending by itself. Clearing the enable bit stops it at once, and later triggers cause no writes.
- R8: A trigger edge that arrives while a block is in progress is held, and it starts the next node's block once that node is loaded.
- R9: Status register (offset 2) bit 0 sets after each acknowledge write and bit 1 sets when the chain ends. Writing 1 to either bit clears it. Bit 2 reads 1 while the channel is active. Both flags are also driven on output pins.
- R10: The trigger select and the 2-bit priority field (control bits [9:8], where 3 is the highest) read back as they were written.
- R11: A memory or descriptor request keeps its address, direction and data unchanged until it is granted. The two ports are never requested in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| trig_i | input | 16 | Hardware trigger inputs |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register offset: 0 control, 1 head, 2 status |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from reg_addr_i |
| desc_req_o | output | 1 | Descriptor read request |
| desc_addr_o | output | 32 | Descriptor word byte address |
| desc_gnt_i | input | 1 | Descriptor request accepted |
| desc_rvalid_i | input | 1 | Descriptor read data valid |
| desc_rdata_i | input | 32 | Descriptor read data |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_gnt_i | input | 1 | Memory request accepted |
| mem_rvalid_i | input | 1 | Memory read data valid |
| mem_rdata_i | input | 32 | Memory read data |
| blk_irq_o | output | 1 | Block-complete flag |
| chain_irq_o | output | 1 | Chain-complete flag |

## Verification
A corrupted node field shows up at the memory port on the next write of that block. A wrong destination or acknowledge address, or a wrong mask, appears in that write. A wrong word count or link becomes visible at the acknowledge write or at the following node fetch. A lost or spurious pending trigger shows within one block: writes either appear while the channel should be waiting, or they never arrive. Flag and enable errors are visible through a single status or control read right after the acknowledge write.

// File: rtl/llt_dma_pkg.sv
package llt_dma_pkg;

    // Number of 32-bit words in one descriptor node
    localparam int unsigned NODE_WORDS = 6;

    // Word order inside a node
    localparam logic [2:0] NW_SRC   = 3'd0;
    localparam logic [2:0] NW_DST   = 3'd1;
    localparam logic [2:0] NW_CNT   = 3'd2;
    localparam logic [2:0] NW_LINK  = 3'd3;
    localparam logic [2:0] NW_ACKA  = 3'd4;
    localparam logic [2:0] NW_ACKM  = 3'd5;

    // Register offsets
    localparam logic [1:0] RG_CTRL = 2'd0;
    localparam logic [1:0] RG_HEAD = 2'd1;
    localparam logic [1:0] RG_STAT = 2'd2;

    // Control register field positions
    localparam int unsigned SEL_LSB  = 4;
    localparam int unsigned PRIO_LSB = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_FWAIT,
        ST_ARM,
        ST_RD,
        ST_RWAIT,
        ST_WR,
        ST_ACK
    } eng_state_e;

endpackage

// File: rtl/llt_trig_sel.sv
module llt_trig_sel #(
    parameter int unsigned NTRIG = 16,
    parameter int unsigned SEL_W = $clog2(NTRIG)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NTRIG-1:0] trig_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             arm_i,
    input  logic             take_i,
    output logic             pend_o
);

    typedef struct packed {
        logic [NTRIG-1:0] prev;
        logic             pend;
    } trig_st_t;

    trig_st_t s_d, s_q;
    logic [NTRIG-1:0] rise;

    for (genvar g = 0; g < NTRIG; g++) begin : g_edge
        assign rise[g] = trig_i[g] & ~s_q.prev[g];
    end

    always_comb begin
        s_d      = s_q;
        s_d.prev = trig_i;
        // a new edge in the same cycle as consumption stays pending
        s_d.pend = arm_i & ((s_q.pend & ~take_i) | rise[sel_i]);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign pend_o = s_q.pend;

endmodule

// File: rtl/llt_regs.sv
module llt_regs
    import llt_dma_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned DW    = 32,
    parameter int unsigned SEL_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             we_i,
    input  logic [1:0]       addr_i,
    input  logic [DW-1:0]    wdata_i,
    output logic [DW-1:0]    rdata_o,
    input  logic             blk_evt_i,
    input  logic             chain_evt_i,
    input  logic             busy_i,
    output logic             en_o,
    output logic [SEL_W-1:0] sel_o,
    output logic [AW-1:0]    head_o,
    output logic             blk_flag_o,
    output logic             chain_flag_o
);

    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] sel;
        logic [1:0]       prio;
        logic [AW-1:0]    head;
        logic             blk;
        logic             chain;
    } reg_st_t;

    reg_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (we_i) begin
            case (addr_i)
                RG_CTRL: begin
                    s_d.en   = wdata_i[0];
                    s_d.sel  = wdata_i[SEL_LSB +: SEL_W];
                    s_d.prio = wdata_i[PRIO_LSB +: 2];
                end
                RG_HEAD: s_d.head = AW'(wdata_i);
                RG_STAT: begin
                    if (wdata_i[0]) s_d.blk   = 1'b0;
                    if (wdata_i[1]) s_d.chain = 1'b0;
                end
                default: ;
            endcase
        end
        // hardware events take precedence over software writes
        if (chain_evt_i) begin
            s_d.en    = 1'b0;
            s_d.chain = 1'b1;
        end
        if (blk_evt_i) s_d.blk = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            RG_CTRL: begin
                rdata_o[0]                = s_q.en;
                rdata_o[SEL_LSB +: SEL_W] = s_q.sel;
                rdata_o[PRIO_LSB +: 2]    = s_q.prio;
            end
            RG_HEAD: rdata_o = DW'(s_q.head);
            RG_STAT: rdata_o[2:0] = {busy_i, s_q.chain, s_q.blk};
            default: ;
        endcase
    end

    assign en_o         = s_q.en;
    assign sel_o        = s_q.sel;
    assign head_o       = s_q.head;
    assign blk_flag_o   = s_q.blk;
    assign chain_flag_o = s_q.chain;

endmodule

// File: rtl/llt_engine.sv
module llt_engine
    import llt_dma_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned DW    = 32,
    parameter int unsigned LEN_W = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          en_i,
    input  logic [AW-1:0] head_i,
    input  logic          pend_i,
    output logic          take_o,
    output logic          busy_o,
    output logic          blk_evt_o,
    output logic          chain_evt_o,
    output logic          desc_req_o,
    output logic [AW-1:0] desc_addr_o,
    input  logic          desc_gnt_i,
    input  logic          desc_rvalid_i,
    input  logic [DW-1:0] desc_rdata_i,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic          mem_gnt_i,
    input  logic          mem_rvalid_i,
    input  logic [DW-1:0] mem_rdata_i
);

    localparam int unsigned   BYTES = DW / 8;
    localparam logic [AW-1:0] STEP  = AW'(BYTES);
    localparam logic [2:0]    LAST  = 3'(NODE_WORDS - 1);

    typedef struct packed {
        eng_state_e       st;
        logic [AW-1:0]    ptr;
        logic [2:0]       widx;
        logic [AW-1:0]    src;
        logic [AW-1:0]    dst;
        logic [LEN_W-1:0] cnt;
        logic [AW-1:0]    link;
        logic [AW-1:0]    ack_a;
        logic [DW-1:0]    ack_m;
        logic [DW-1:0]    data;
    } eng_st_t;

    eng_st_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        take_o      = 1'b0;
        blk_evt_o   = 1'b0;
        chain_evt_o = 1'b0;
        desc_req_o  = 1'b0;
        desc_addr_o = s_q.ptr + AW'(s_q.widx) * STEP;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = s_q.src;
        mem_wdata_o = s_q.data;

        case (s_q.st)
            ST_IDLE: begin
                if (en_i) begin
                    s_d.ptr  = head_i;
                    s_d.widx = '0;
                    s_d.st   = ST_FETCH;
                end
            end
            ST_FETCH: begin
                desc_req_o = 1'b1;
                if (desc_gnt_i) s_d.st = ST_FWAIT;
            end
            ST_FWAIT: begin
                if (desc_rvalid_i) begin
                    case (s_q.widx)
                        NW_SRC:  s_d.src   = AW'(desc_rdata_i);
                        NW_DST:  s_d.dst   = AW'(desc_rdata_i);
                        NW_CNT:  s_d.cnt   = desc_rdata_i[LEN_W-1:0];
                        NW_LINK: s_d.link  = AW'(desc_rdata_i);
                        NW_ACKA: s_d.ack_a = AW'(desc_rdata_i);
                        default: s_d.ack_m = desc_rdata_i;
                    endcase
                    if (s_q.widx == LAST) begin
                        s_d.st = ST_ARM;
                    end else begin
                        s_d.widx = s_q.widx + 3'd1;
                        s_d.st   = ST_FETCH;
                    end
                end
            end
            ST_ARM: begin
                if (pend_i) begin
                    take_o = 1'b1;
                    s_d.st = (s_q.cnt == '0) ? ST_ACK : ST_RD;
                end
            end
            ST_RD: begin
                mem_req_o = 1'b1;
                if (mem_gnt_i) s_d.st = ST_RWAIT;
            end
            ST_RWAIT: begin
                if (mem_rvalid_i) begin
                    s_d.data = mem_rdata_i;
                    s_d.st   = ST_WR;
                end
            end
            ST_WR: begin
                mem_req_o  = 1'b1;
                mem_we_o   = 1'b1;
                mem_addr_o = s_q.dst;
                if (mem_gnt_i) begin
                    s_d.src = s_q.src + STEP;
                    s_d.dst = s_q.dst + STEP;
                    s_d.cnt = s_q.cnt - LEN_W'(1);
                    s_d.st  = (s_q.cnt == LEN_W'(1)) ? ST_ACK : ST_RD;
                end
            end
            ST_ACK: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = s_q.ack_a;
                mem_wdata_o = s_q.ack_m;
                if (mem_gnt_i) begin
                    blk_evt_o = 1'b1;
                    if (s_q.link == '0) begin
                        chain_evt_o = 1'b1;
                        s_d.st      = ST_IDLE;
                    end else begin
                        s_d.ptr  = s_q.link;
                        s_d.widx = '0;
                        s_d.st   = ST_FETCH;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase

        // software termination
        if (!en_i && s_q.st != ST_IDLE) s_d.st = ST_IDLE;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign busy_o = (s_q.st != ST_IDLE);

endmodule

// File: rtl/llt_dma_chan.sv
module llt_dma_chan #(
    parameter int unsigned AW    = 32,
    parameter int unsigned DW    = 32,
    parameter int unsigned NTRIG = 16,
    parameter int unsigned LEN_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NTRIG-1:0] trig_i,
    input  logic             reg_we_i,
    input  logic [1:0]       reg_addr_i,
    input  logic [DW-1:0]    reg_wdata_i,
    output logic [DW-1:0]    reg_rdata_o,
    output logic             desc_req_o,
    output logic [AW-1:0]    desc_addr_o,
    input  logic             desc_gnt_i,
    input  logic             desc_rvalid_i,
    input  logic [DW-1:0]    desc_rdata_i,
    output logic             mem_req_o,
    output logic             mem_we_o,
    output logic [AW-1:0]    mem_addr_o,
    output logic [DW-1:0]    mem_wdata_o,
    input  logic             mem_gnt_i,
    input  logic             mem_rvalid_i,
    input  logic [DW-1:0]    mem_rdata_i,
    output logic             blk_irq_o,
    output logic             chain_irq_o
);

    localparam int unsigned SEL_W = $clog2(NTRIG);

    logic             ch_en;
    logic             ch_busy;
    logic [SEL_W-1:0] ch_sel;
    logic [AW-1:0]    ch_head;
    logic             ch_pend;
    logic             ch_take;
    logic             ch_blk_evt;
    logic             ch_chain_evt;

    llt_regs #(.AW(AW), .DW(DW), .SEL_W(SEL_W)) u_regs (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .we_i         (reg_we_i),
        .addr_i       (reg_addr_i),
        .wdata_i      (reg_wdata_i),
        .rdata_o      (reg_rdata_o),
        .blk_evt_i    (ch_blk_evt),
        .chain_evt_i  (ch_chain_evt),
        .busy_i       (ch_busy),
        .en_o         (ch_en),
        .sel_o        (ch_sel),
        .head_o       (ch_head),
        .blk_flag_o   (blk_irq_o),
        .chain_flag_o (chain_irq_o)
    );

    llt_trig_sel #(.NTRIG(NTRIG), .SEL_W(SEL_W)) u_trig (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .trig_i (trig_i),
        .sel_i  (ch_sel),
        .arm_i  (ch_en),
        .take_i (ch_take),
        .pend_o (ch_pend)
    );

    llt_engine #(.AW(AW), .DW(DW), .LEN_W(LEN_W)) u_eng (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .en_i          (ch_en),
        .head_i        (ch_head),
        .pend_i        (ch_pend),
        .take_o        (ch_take),
        .busy_o        (ch_busy),
        .blk_evt_o     (ch_blk_evt),
        .chain_evt_o   (ch_chain_evt),
        .desc_req_o    (desc_req_o),
        .desc_addr_o   (desc_addr_o),
        .desc_gnt_i    (desc_gnt_i),
        .desc_rvalid_i (desc_rvalid_i),
        .desc_rdata_i  (desc_rdata_i),
        .mem_req_o     (mem_req_o),
        .mem_we_o      (mem_we_o),
        .mem_addr_o    (mem_addr_o),
        .mem_wdata_o   (mem_wdata_o),
        .mem_gnt_i     (mem_gnt_i),
        .mem_rvalid_i  (mem_rvalid_i),
        .mem_rdata_i   (mem_rdata_i)
    );

endmodule

// File: rtl/llt_dma_chan_chk.sv
module llt_dma_chan_chk #(
    parameter int unsigned AW = 32,
    parameter int unsigned DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          busy,
    input logic          blk_irq,
    input logic          chain_irq,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          mem_gnt,
    input logic          desc_req,
    input logic [AW-1:0] desc_addr,
    input logic          desc_gnt
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !desc_req)); // R1

    AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && desc_req)); // R11

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mem_req && !mem_gnt) |=>
        (!en || (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)))); // R11

    AST_DESC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && desc_req && !desc_gnt) |=> (!en || (desc_req && $stable(desc_addr)))); // R11

    AST_CHAIN_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chain_irq) |-> (!busy && !en)); // R6

    AST_CHAIN_WITH_BLK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chain_irq) |-> blk_irq); // R9

endmodule

bind llt_dma_chan llt_dma_chan_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk_i),
    .rst_n     (rst_ni),
    .en        (ch_en),
    .busy      (ch_busy),
    .blk_irq   (blk_irq_o),
    .chain_irq (chain_irq_o),
    .mem_req   (mem_req_o),
    .mem_we    (mem_we_o),
    .mem_addr  (mem_addr_o),
    .mem_wdata (mem_wdata_o),
    .mem_gnt   (mem_gnt_i),
    .desc_req  (desc_req_o),
    .desc_addr (desc_addr_o),
    .desc_gnt  (desc_gnt_i)
);

// File: tb/llt_dma_chan_test.sv
module llt_dma_chan_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] trig = '0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        desc_req, desc_gnt = 1'b0, desc_rvalid = 1'b0;
    logic [31:0] desc_addr, desc_rdata = '0;
    logic        mem_req, mem_we, mem_gnt = 1'b0, mem_rvalid = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic        blk_irq, chain_irq;

    always #5 clk = ~clk;

    llt_dma_chan uut (
        .clk_i(clk), .rst_ni(rst_n), .trig_i(trig),
        .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .desc_req_o(desc_req), .desc_addr_o(desc_addr), .desc_gnt_i(desc_gnt),
        .desc_rvalid_i(desc_rvalid), .desc_rdata_i(desc_rdata),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
        .mem_gnt_i(mem_gnt), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
        .blk_irq_o(blk_irq), .chain_irq_o(chain_irq)
    );

    int n_vec = 0;
    int n_bad = 0;
    logic [31:0] mem [0:1023];
    logic [63:0] exp_q [$];
    string       cur_req = "R1";
    int          cyc = 0;
    logic        m_pend = 1'b0, d_pend = 1'b0;
    logic [31:0] m_ra = '0, d_ra = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    // memory / descriptor model and write monitor (scoreboard consumer)
    always @(negedge clk) begin
        cyc++;
        mem_rvalid  = m_pend;
        mem_rdata   = m_pend ? mem[m_ra[11:2]] : '0;
        m_pend      = 1'b0;
        desc_rvalid = d_pend;
        desc_rdata  = d_pend ? mem[d_ra[11:2]] : '0;
        d_pend      = 1'b0;
        mem_gnt     = (cyc % 3) != 0;
        desc_gnt    = (cyc % 4) != 1;
        if (rst_n && mem_req && mem_gnt) begin
            if (mem_we) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, cur_req, "unexpected write addr", mem_addr, 32'h0);
                end else begin
                    logic [63:0] e;
                    e = exp_q.pop_front();
                    chk(mem_addr == e[63:32], cur_req, "write address", mem_addr, e[63:32]);
                    chk(mem_wdata == e[31:0], cur_req, "write data", mem_wdata, e[31:0]);
                end
                mem[mem_addr[11:2]] = mem_wdata;
            end else begin
                m_pend = 1'b1;
                m_ra   = mem_addr;
            end
        end
        if (rst_n && desc_req && desc_gnt) begin
            d_pend = 1'b1;
            d_ra   = desc_addr;
        end
    end

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic put_node(input logic [31:0] at, input logic [31:0] s, input logic [31:0] dd,
                            input logic [31:0] n, input logic [31:0] lk,
                            input logic [31:0] aa, input logic [31:0] am);
        mem[at[11:2]]     = s;
        mem[at[11:2] + 1] = dd;
        mem[at[11:2] + 2] = n;
        mem[at[11:2] + 3] = lk;
        mem[at[11:2] + 4] = aa;
        mem[at[11:2] + 5] = am;
    endtask

    // scoreboard producer: expected writes of one block
    task automatic expect_node(input logic [31:0] s, input logic [31:0] dd, input int n,
                               input logic [31:0] aa, input logic [31:0] am);
        for (int i = 0; i < n; i++)
            exp_q.push_back({dd + 32'(4 * i), mem[s[11:2] + 10'(i)]});
        exp_q.push_back({aa, am});
    endtask

    task automatic pulse(input int idx);
        @(negedge clk); trig[idx] = 1'b1;
        repeat (2) @(negedge clk);
        trig[idx] = 1'b0;
    endtask

    task automatic wait_stat(input logic [31:0] mask, input string req);
        logic [31:0] v = '0;
        bit seen = 1'b0;
        for (int i = 0; i < 3000 && !seen; i++) begin
            reg_rd(2'd2, v);
            if ((v & mask) != 0) seen = 1'b1;
        end
        chk(seen, req, "status flag never set", v, mask);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, got %0d expected 0 hung cycles", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        for (int i = 0; i < 128; i++) mem[64 + i] = 32'hA500_0000 + 32'(i) * 32'h0001_0203;

        repeat (4) @(negedge clk);
        // R1: reset state
        chk(!mem_req && !desc_req, "R1", "requests in reset", {30'b0, mem_req, desc_req}, 32'h0);
        rst_n = 1'b1;
        reg_rd(2'd0, v); chk(v == 32'h0, "R1", "ctrl after reset", v, 32'h0);
        reg_rd(2'd1, v); chk(v == 32'h0, "R1", "head after reset", v, 32'h0);
        reg_rd(2'd2, v); chk(v == 32'h0, "R1", "status after reset", v, 32'h0);

        // two-node chain A -> B, trigger 3, priority 3
        cur_req = "R4";
        put_node(32'h040, 32'h100, 32'h200, 4, 32'h060, 32'hF00, 32'h8);
        put_node(32'h060, 32'h140, 32'h280, 3, 32'h000, 32'hF04, 32'h4);
        expect_node(32'h100, 32'h200, 4, 32'hF00, 32'h8);
        expect_node(32'h140, 32'h280, 3, 32'hF04, 32'h4);
        reg_wr(2'd1, 32'h040);
        reg_wr(2'd0, 32'h331);
        repeat (40) @(negedge clk);
        chk(exp_q.size() == 9, "R2", "writes before any trigger", 32'(exp_q.size()), 32'd9);
        reg_rd(2'd0, v); chk(v == 32'h331, "R10", "ctrl readback", v, 32'h331);
        pulse(5); pulse(2);
        repeat (30) @(negedge clk);
        chk(exp_q.size() == 9, "R3", "writes after unselected triggers", 32'(exp_q.size()), 32'd9);
        reg_rd(2'd2, v); chk(v == 32'h4, "R9", "busy while waiting", v, 32'h4);
        pulse(3);
        repeat (3) @(negedge clk);
        pulse(3); // R8: lands during block A
        wait_stat(32'h2, "R6");
        chk(exp_q.size() == 0, "R8", "pending writes after chain", 32'(exp_q.size()), 32'h0);
        reg_rd(2'd2, v); chk(v == 32'h3, "R9", "status at chain end", v, 32'h3);
        reg_rd(2'd0, v); chk(v == 32'h330, "R6", "enable self-cleared", v, 32'h330);
        chk(blk_irq && chain_irq, "R9", "flag pins", {30'b0, blk_irq, chain_irq}, 32'h3);
        reg_wr(2'd2, 32'h1);
        reg_rd(2'd2, v); chk(v == 32'h2, "R9", "block flag cleared", v, 32'h2);
        reg_wr(2'd2, 32'h2);
        reg_rd(2'd2, v); chk(v == 32'h0, "R9", "chain flag cleared", v, 32'h0);

        // zero-length node
        cur_req = "R5";
        put_node(32'h080, 32'h180, 32'h2C0, 0, 32'h000, 32'hF08, 32'h1);
        expect_node(32'h180, 32'h2C0, 0, 32'hF08, 32'h1);
        reg_wr(2'd1, 32'h080);
        reg_wr(2'd0, 32'h101);
        repeat (20) @(negedge clk);
        pulse(0);
        wait_stat(32'h2, "R5");
        chk(exp_q.size() == 0, "R5", "zero-length ack", 32'(exp_q.size()), 32'h0);
        reg_rd(2'd0, v); chk(v == 32'h100, "R10", "ctrl readback low priority", v, 32'h100);
        reg_wr(2'd2, 32'h3);

        // circular chain C -> D -> C, trigger 15
        cur_req = "R7";
        put_node(32'h0A0, 32'h300, 32'h380, 2, 32'h0C0, 32'hF10, 32'h10);
        put_node(32'h0C0, 32'h320, 32'h3C0, 1, 32'h0A0, 32'hF14, 32'h20);
        reg_wr(2'd1, 32'h0A0);
        reg_wr(2'd0, 32'h0F1);
        for (int k = 0; k < 5; k++) begin
            if (k % 2 == 0) expect_node(32'h300, 32'h380, 2, 32'hF10, 32'h10);
            else            expect_node(32'h320, 32'h3C0, 1, 32'hF14, 32'h20);
            pulse(15);
            wait_stat(32'h1, "R7");
            reg_wr(2'd2, 32'h1);
            chk(exp_q.size() == 0, "R7", "circular block done", 32'(exp_q.size()), 32'h0);
        end
        reg_rd(2'd2, v); chk(v == 32'h4, "R7", "loop still running", v, 32'h4);
        reg_wr(2'd0, 32'h0F0);
        reg_rd(2'd2, v); chk(v == 32'h0, "R7", "idle after terminate", v, 32'h0);
        pulse(15);
        repeat (30) @(negedge clk);
        chk(!mem_req && !desc_req, "R7", "quiet after terminate", {30'b0, mem_req, desc_req}, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule